// File: doc/BRIEF.md
# Cartridge Bus Address Translator

This block sits between the console CPU bus and the backing memory of a RAM-based development cartridge. On every clock it takes the 24-bit CPU address, the active-low ROM-select strobe from the console and a layout select. From these it works out whether the access targets the program ROM image, the battery save RAM, or nothing. It also produces the flat byte offset into whichever backing region is hit. The cartridge controller uses the enables and the offset to steer the access into one shared memory.

Two bank layouts are supported. The first is a layout of 32 KiB pieces, where the ROM sits in the upper half of each bank and save RAM sits in the lower half of the top banks. The second is a 64 KiB-per-bank layout, with a small save-RAM window low in the system banks. Two size masks, each set to the image size minus one, cut the offsets down so that undersized images repeat through their address space. The result is registered, and the block runs from an asynchronous active-low reset that is released in step with the clock.

Top module: `cart_xlate`

## Requirements
- R1: While reset is asserted and until the first edge after its synchronous release, rom_en and sram_en are 0, open_bus is 1 and phys_ofs is 0.
- R2: The outputs for an input set sampled at a rising clock edge appear just after that edge and hold until the next edge (one cycle of latency).
- R3: With mode_hi=0, an access with cpu_addr[15]=1 to any bank other than 0x7E/0x7F (bit 23 ignored, so 0x80-0xFF mirror 0x00-0x7F except that 0xFE/0xFF decode as ROM) is a ROM access with offset (bank[6:0] * 0x8000) + cpu_addr[14:0].
- R4: With mode_hi=0, offsets 0x0000-0x7FFF of banks 0x40-0x6F and 0xC0-0xEF are ROM accesses and give the same offset as the same address with cpu_addr[15]=1.
- R5: With mode_hi=0, offsets 0x0000-0x7FFF of banks 0x70-0x7D and 0xF0-0xFF are save-RAM accesses with offset (bank[3:0] * 0x8000) + cpu_addr[14:0]. The upper halves of those banks stay ROM.
- R6: With mode_hi=1, offsets 0x6000-0x7FFF of banks 0x20-0x3F and 0xA0-0xBF are save-RAM accesses with offset (bank[3:0] * 0x2000) + cpu_addr[12:0], so banks 0x20-0x2F alias 0x30-0x3F.
- R7: With mode_hi=1, banks 0x40-0x7D and 0xC0-0xFF are ROM over 0x0000-0xFFFF, and banks 0x00-0x3F and 0x80-0xBF are ROM over 0x8000-0xFFFF. Both cases use offset (bank[5:0] * 0x10000) + cpu_addr[15:0].
- R8: Banks 0x7E and 0x7F are never claimed by the cartridge, in either layout.
- R9: ROM is enabled only while romsel_n was 0. Save-RAM decoding does not depend on romsel_n.
- R10: The ROM offset is ANDed with rom_mask and the save-RAM offset with sram_mask before it is driven on phys_ofs.
- R11: When neither ROM nor save RAM is enabled, open_bus is 1 and phys_ofs is 0. Otherwise open_bus is 0, and at most one enable is ever 1.
- R12: mode_hi selects the layout: 0 selects the 32 KiB-piece layout and 1 selects the 64 KiB-bank layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_hi | input | 1 | Layout select: 0 = 32 KiB pieces, 1 = 64 KiB banks |
| romsel_n | input | 1 | Console ROM-select strobe, active low |
| cpu_addr | input | 24 | CPU bus address, bank in bits 23:16 |
| rom_mask | input | 22 | ROM image size minus one |
| sram_mask | input | 19 | Save-RAM size minus one |
| rom_en | output | 1 | Access targets the ROM image |
| sram_en | output | 1 | Access targets save RAM |
| open_bus | output | 1 | Access targets nothing on the cartridge |
| phys_ofs | output | 22 | Masked byte offset into the selected region |

## Verification
Every result (both enables, the open-bus flag and the offset) is due exactly one rising edge after the inputs are applied. The bench therefore drives each vector on a falling edge and compares all four outputs on the following falling edge, half a cycle clear of the edge that loads them. One dedicated check samples right after a new vector is driven, before its edge, to confirm that the previous result is still held. Reset values are read while reset is held low, and the sweep starts only after the synchronous release has passed through.

// File: rtl/cart_xlate_pkg.sv
package cart_xlate_pkg;
  parameter int CPU_AW     = 24;
  parameter int BANK_W     = 8;
  parameter int ROM_OFS_W  = 22;
  parameter int SRAM_OFS_W = 19;
  parameter int PHYS_W     = ROM_OFS_W;

  typedef struct packed {
    logic                  rom_hit;
    logic                  sram_hit;
    logic [ROM_OFS_W-1:0]  rom_ofs;
    logic [SRAM_OFS_W-1:0] sram_ofs;
  } map_res_t;
endpackage

// File: rtl/cart_rst_sync.sv
module cart_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cart_lo_map.sv
module cart_lo_map
  import cart_xlate_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  output map_res_t          res
);
  logic [BANK_W-1:0] bank;
  logic a15, wram, sram_win;

  always_comb begin
    bank     = addr[CPU_AW-1:CPU_AW-BANK_W];
    a15      = addr[15];
    wram     = (bank[7:1] == 7'b0111111);
    // lower half of 70-7D and F0-FF
    sram_win = !a15 && (bank[6:4] == 3'b111) && (bank[7] || (bank[3:1] != 3'b111));
    res.sram_hit = sram_win;
    // upper half everywhere, lower half mirrors upper in 40-6F / C0-EF
    res.rom_hit  = !wram && !sram_win && (a15 || bank[6]);
    res.rom_ofs  = {bank[6:0], addr[14:0]};
    res.sram_ofs = {bank[3:0], addr[14:0]};
  end
endmodule

// File: rtl/cart_hi_map.sv
module cart_hi_map
  import cart_xlate_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  output map_res_t          res
);
  logic [BANK_W-1:0] bank;
  logic wram;

  always_comb begin
    bank         = addr[CPU_AW-1:CPU_AW-BANK_W];
    wram         = (bank[7:1] == 7'b0111111);
    res.sram_hit = (bank[6:5] == 2'b01) && (addr[15:13] == 3'b011);
    res.rom_hit  = !wram && (bank[6] || addr[15]);
    res.rom_ofs  = {bank[5:0], addr[15:0]};
    res.sram_ofs = {{(SRAM_OFS_W-17){1'b0}}, bank[3:0], addr[12:0]};
  end
endmodule

// File: rtl/cart_xlate.sv
module cart_xlate
  import cart_xlate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_hi,
  input  logic                  romsel_n,
  input  logic [CPU_AW-1:0]     cpu_addr,
  input  logic [ROM_OFS_W-1:0]  rom_mask,
  input  logic [SRAM_OFS_W-1:0] sram_mask,
  output logic                  rom_en,
  output logic                  sram_en,
  output logic                  open_bus,
  output logic [PHYS_W-1:0]     phys_ofs
);
  localparam int PAD_W = PHYS_W - SRAM_OFS_W;

  logic     rst_sync_n;
  map_res_t lo_res, hi_res, sel_res;
  logic     rom_d, sram_d, open_d;
  logic [PHYS_W-1:0] ofs_d;

  cart_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cart_lo_map u_lo (.addr(cpu_addr), .res(lo_res));
  cart_hi_map u_hi (.addr(cpu_addr), .res(hi_res));

  // next-state: R12 layout select, R9 strobe gate, R10 masks
  always_comb begin
    sel_res = mode_hi ? hi_res : lo_res;
    rom_d   = sel_res.rom_hit && !romsel_n;
    sram_d  = sel_res.sram_hit;
    open_d  = !(rom_d || sram_d);
    if (rom_d)       ofs_d = sel_res.rom_ofs & rom_mask;
    else if (sram_d) ofs_d = {{PAD_W{1'b0}}, sel_res.sram_ofs & sram_mask};
    else             ofs_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rom_en   <= 1'b0;
      sram_en  <= 1'b0;
      open_bus <= 1'b1;
      phys_ofs <= '0;
    end else begin
      rom_en   <= rom_d;
      sram_en  <= sram_d;
      open_bus <= open_d;
      phys_ofs <= ofs_d;
    end
  end

  AST_ROM_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rom_en |-> !$past(romsel_n)); // R9
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rom_en && sram_en)); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    open_bus |-> (phys_ofs == '0) && !rom_en && !sram_en); // R11
  AST_LO_SRAM_LOWER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sram_en && !$past(mode_hi)) |-> !$past(cpu_addr[15])); // R5
  AST_HI_SRAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sram_en && $past(mode_hi)) |-> ($past(cpu_addr[15:13]) == 3'b011)); // R6
  AST_ROM_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rom_en |-> ((phys_ofs & ~$past(rom_mask)) == '0)); // R10
  AST_NO_WRAM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(cpu_addr[23:17]) == 7'b0111111) |-> open_bus); // R8
endmodule

// File: tb/cart_xlate_test.sv
module cart_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_hi;
  logic        romsel_n;
  logic [23:0] cpu_addr;
  logic [21:0] rom_mask;
  logic [18:0] sram_mask;
  logic        rom_en, sram_en, open_bus;
  logic [21:0] phys_ofs;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  cart_xlate uut (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .romsel_n(romsel_n),
    .cpu_addr(cpu_addr), .rom_mask(rom_mask), .sram_mask(sram_mask),
    .rom_en(rom_en), .sram_en(sram_en), .open_bus(open_bus), .phys_ofs(phys_ofs)
  );

  task automatic check(input string req, input logic r, input logic s, input logic o,
                       input logic [21:0] ofs);
    n_checks++;
    if (rom_en !== r || sram_en !== s || open_bus !== o || phys_ofs !== ofs) begin
      n_fail++;
      $display("FAIL %s mode=%0d addr=%06h rs=%0b: got rom=%0b sram=%0b open=%0b ofs=%06h exp rom=%0b sram=%0b open=%0b ofs=%06h",
               req, mode_hi, cpu_addr, romsel_n, rom_en, sram_en, open_bus, phys_ofs, r, s, o, ofs);
    end
  endtask

  // independent reference model of the requirements
  task automatic expect_of(input int hi, input int bank, input int off, input int rs,
                           input int rmask, input int smask,
                           output logic r, output logic s, output logic [21:0] ofs,
                           output string req);
    int b7;
    bit wram, sr, rd;
    int lin;
    b7   = bank % 128;
    wram = (bank == 'h7E) || (bank == 'h7F);
    if (hi == 0) begin
      sr  = (off < 'h8000) && ((bank >= 'h70 && bank <= 'h7D) || bank >= 'hF0);
      rd  = !wram && !sr && (off >= 'h8000 || b7 >= 'h40);
      lin = sr ? (bank % 16) * 'h8000 + off % 'h8000 : b7 * 'h8000 + off % 'h8000;
      req = sr ? "R5" : (rd ? (off < 'h8000 ? "R4" : "R3") : "R11");
    end else begin
      sr  = (b7 >= 'h20 && b7 <= 'h3F) && off >= 'h6000 && off < 'h8000;
      rd  = !wram && (b7 >= 'h40 || off >= 'h8000);
      lin = sr ? (bank % 16) * 'h2000 + (off - 'h6000) : (b7 % 64) * 'h10000 + off;
      req = sr ? "R6" : (rd ? "R7" : "R11");
    end
    if (wram) req = "R8";
    if (rd && rs != 0 && !sr) req = "R9";
    r   = rd && (rs == 0);
    s   = sr;
    ofs = r ? 22'(lin & rmask) : (s ? 22'(lin & smask) : 22'd0);
  endtask

  initial begin
    int offs[8] = '{'h0000, 'h1FFF, 'h6000, 'h7ABC, 'h7FFF, 'h8000, 'hABCD, 'hFFFF};
    logic er, es;
    logic [21:0] eo;
    string req;
    rst_n = 1'b0; mode_hi = 1'b0; romsel_n = 1'b0;
    cpu_addr = 24'h008000; rom_mask = '1; sram_mask = '1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b1, 22'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b1, 22'd0);
    repeat (3) @(negedge clk);

    // R2: previous result held until the next edge
    mode_hi = 1'b0; romsel_n = 1'b0; cpu_addr = 24'h028123;
    @(negedge clk);
    cpu_addr = 24'h700000;
    #1 check("R2", 1'b1, 1'b0, 1'b0, 22'h010123);
    @(negedge clk);
    check("R2", 1'b0, 1'b1, 1'b0, 22'h000000);

    for (int ms = 0; ms < 2; ms++) begin
      rom_mask  = (ms == 0) ? 22'h3FFFFF : 22'h0FFFFF;
      sram_mask = (ms == 0) ? 19'h7FFFF  : 19'h01FFF;
      for (int hi = 0; hi < 2; hi++) begin      // R12 both layouts
        for (int bank = 0; bank < 256; bank++) begin
          for (int k = 0; k < 8; k++) begin
            for (int rs = 0; rs < 2; rs++) begin
              mode_hi  = hi[0];
              romsel_n = rs[0];
              cpu_addr = 24'((bank << 16) | offs[k]);
              expect_of(hi, bank, offs[k], rs, int'(rom_mask), int'(sram_mask), er, es, eo, req);
              if (ms == 1 && (er || es)) req = "R10";
              @(negedge clk);
              check(req, er, es, !(er || es), eo);
            end
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (60000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog: got running expected done");
        end
      end
      wait (done);
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule